// File: doc/BRIEF.md
# Four-Stage Event Sequencer

This block merges four event-hit strobes and one clear strobe into a single trigger pulse. It sits behind a set of address or data comparators, which are not part of this block. Each hit strobe sets its own stage switch. The trigger fires when the switches reach the selected completion condition.

There are two modes. In ordered mode the switches must be set one after another, from a selectable starting stage up to the last stage, so the chain is four, three, two or one stages deep. In unordered mode all four switches must be set, in any order.

The clear strobe drops all progress. After each completion the switches re-arm on their own. An optional counter stage sits behind the completion logic. It can require a programmed number of completions before the trigger fires, or it can hold the trigger back for a programmed number of clocks.

Top module: `evt_sequencer`

## Requirements
- R1: While `rst_ni` is low, `trig_o` is 0 and all stage switches are cleared.
- R2: With `seq_mode_i`=1, stage k sets on `hit_i[k]` only if k equals `first_stage_i`, or if stage k-1 was already set in an earlier cycle. Hits on two stages in the same cycle therefore do not chain.
- R3: With `seq_mode_i`=1, `first_stage_i` (0..3) selects the first active stage. Hits on stages below it are ignored. Completion is the cycle in which stage 3 sets.
- R4: `clr_i` high clears every stage switch. It takes priority over any hit in the same cycle and suppresses completion in that cycle.
- R5: With `seq_mode_i`=0, completion is the cycle in which the last of the four switches becomes set. Order does not matter, and several hits may arrive in one cycle.
- R6: After a completion all switches return to cleared. With the counter off, `trig_o` is high for exactly the one cycle after the completing edge.
- R7: `cnt_mode_i`=1 (match): `trig_o` fires on every Nth completion, where N is `cnt_limit_i`. A limit of 0 or 1 fires on every completion.
- R8: `cnt_mode_i`=2 (delay): `trig_o` fires `cnt_limit_i` clocks later than it would with the counter off. While a delay is pending, further completions are ignored. A limit of 0 behaves like counter off.
- R9: `cnt_mode_i`=0 and `cnt_mode_i`=3 both disable the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hit_i | input | 4 | Event-hit strobes; bit k sets stage k |
| clr_i | input | 1 | Clear strobe |
| seq_mode_i | input | 1 | 1 = ordered, 0 = unordered |
| first_stage_i | input | 2 | First active stage in ordered mode |
| cnt_mode_i | input | 2 | 0 off, 1 match, 2 delay, 3 off |
| cnt_limit_i | input | 32 | Completion count or delay in clocks |
| trig_o | output | 1 | Trigger pulse |

## Verification
Completion is decided combinationally from the current inputs and the registered switches. The trigger register captures it at the same clock edge. So with the counter off or in match mode, `trig_o` is due just after the edge that samples the completing hit, and with a delay of D it is due D edges later.

The bench drives each stimulus for one cycle and samples `trig_o` one time unit after the next rising edge. It compares the output every cycle against a progress model written from the requirements. Silent cycles are checked as well as pulses. In delay mode the bench keeps stepping idle cycles and checks each one, so an early, late or doubled trigger is caught.

// File: rtl/evt_seq_pkg.sv
package evt_seq_pkg;
  typedef enum logic [1:0] {
    CM_OFF   = 2'd0,
    CM_MATCH = 2'd1,
    CM_DELAY = 2'd2,
    CM_RSVD  = 2'd3
  } cnt_mode_e;
endpackage

// File: rtl/evt_seq_stages.sv
module evt_seq_stages #(
  parameter int N_STG = 4,
  localparam int SEL_W = $clog2(N_STG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_STG-1:0] hit_i,
  input  logic             clr_i,
  input  logic             seq_mode_i,
  input  logic [SEL_W-1:0] first_i,
  output logic [N_STG-1:0] sw_o,
  output logic             done_o
);
  logic [N_STG-1:0] sw_q, sw_set, sw_nx;

  for (genvar k = 0; k < N_STG; k++) begin : g_stg
    logic active, pred;
    assign active = (k >= int'(first_i));
    if (k == 0) begin : g_head
      assign pred = (first_i == '0);
    end else begin : g_body
      assign pred = (int'(first_i) == k) | sw_q[k-1];
    end
    assign sw_set[k] = hit_i[k] & (!seq_mode_i | (active & pred));
  end

  assign sw_nx  = sw_q | sw_set;
  assign done_o = !clr_i & (seq_mode_i ? sw_nx[N_STG-1] : &sw_nx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sw_q <= '0;
    else if (clr_i || done_o)   sw_q <= '0;
    else                        sw_q <= sw_nx;
  end

  assign sw_o = sw_q;
endmodule

// File: rtl/evt_seq_counter.sv
module evt_seq_counter
  import evt_seq_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  cnt_mode_e        mode_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             trig_o
);
  logic [CNT_W-1:0] occ_q, rem_q;
  logic             busy_q, fire, occ_hit;

  assign occ_hit = ({1'b0, occ_q} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, limit_i};

  always_comb begin
    unique case (mode_i)
      CM_MATCH: fire = done_i & occ_hit;
      CM_DELAY: fire = busy_q ? (rem_q == {{(CNT_W-1){1'b0}}, 1'b1})
                              : (done_i & (limit_i == '0));
      default:  fire = done_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q <= '0;
    end else if (mode_i != CM_MATCH) begin
      occ_q <= '0;
    end else if (done_i) begin
      occ_q <= occ_hit ? '0 : occ_q + 1'b1;
    end
  end

  // pending delay blocks new completions
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
    end else if (mode_i != CM_DELAY) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
    end else if (busy_q) begin
      busy_q <= (rem_q != {{(CNT_W-1){1'b0}}, 1'b1});
      rem_q  <= rem_q - 1'b1;
    end else if (done_i && limit_i != '0) begin
      busy_q <= 1'b1;
      rem_q  <= limit_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_o <= 1'b0;
    else         trig_o <= fire;
  end
endmodule

// File: rtl/evt_sequencer.sv
module evt_sequencer
  import evt_seq_pkg::*;
#(
  parameter int N_STG = 4,
  parameter int CNT_W = 32,
  localparam int SEL_W = $clog2(N_STG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_STG-1:0] hit_i,
  input  logic             clr_i,
  input  logic             seq_mode_i,
  input  logic [SEL_W-1:0] first_stage_i,
  input  logic [1:0]       cnt_mode_i,
  input  logic [CNT_W-1:0] cnt_limit_i,
  output logic             trig_o
);
  logic [N_STG-1:0] stg_sw;
  logic             stg_done;

  evt_seq_stages #(.N_STG(N_STG)) u_stg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (hit_i),
    .clr_i      (clr_i),
    .seq_mode_i (seq_mode_i),
    .first_i    (first_stage_i),
    .sw_o       (stg_sw),
    .done_o     (stg_done)
  );

  evt_seq_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (stg_done),
    .mode_i  (cnt_mode_e'(cnt_mode_i)),
    .limit_i (cnt_limit_i),
    .trig_o  (trig_o)
  );
endmodule

// File: rtl/evt_sequencer_chk.sv
module evt_sequencer_chk #(
  parameter int N_STG = 4,
  parameter int CNT_W = 32,
  localparam int SEL_W = $clog2(N_STG)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             seq_mode_i,
  input logic [SEL_W-1:0] first_stage_i,
  input logic [1:0]       cnt_mode_i,
  input logic [CNT_W-1:0] cnt_limit_i,
  input logic [N_STG-1:0] sw_i,
  input logic             done_i,
  input logic             trig_o
);
  // R1
  always_comb begin
    if (!rst_ni) a_r1_reset_quiet: assert (!trig_o && sw_i == '0);
  end

  // R4
  a_r4_clear_wipes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (sw_i == '0));

  a_r4_clear_no_trig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && cnt_mode_i == 2'd0) |=> !trig_o);

  // R6
  a_r6_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (sw_i == '0));

  a_r6_direct_trig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_mode_i == 2'd0) |=> (trig_o == $past(done_i)));

  // R7
  a_r7_limit_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_mode_i == 2'd1 && cnt_limit_i <= 1 && done_i) |=> trig_o);

  // R2
  for (genvar k = 1; k < N_STG; k++) begin : g_ord
    a_r2_in_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sw_i[k] && !$past(sw_i[k]) && $past(seq_mode_i) && int'($past(first_stage_i)) < k)
        |-> $past(sw_i[k-1]));
  end
endmodule

bind evt_sequencer evt_sequencer_chk #(.N_STG(N_STG), .CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .clr_i         (clr_i),
  .seq_mode_i    (seq_mode_i),
  .first_stage_i (first_stage_i),
  .cnt_mode_i    (cnt_mode_i),
  .cnt_limit_i   (cnt_limit_i),
  .sw_i          (stg_sw),
  .done_i        (stg_done),
  .trig_o        (trig_o)
);

// File: tb/sim_evt_sequencer.sv
`timescale 1ns/1ps
module sim_evt_sequencer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  hit_i = '0;
  logic        clr_i = 1'b0;
  logic        seq_mode_i = 1'b1;
  logic [1:0]  first_stage_i = '0;
  logic [1:0]  cnt_mode_i = '0;
  logic [31:0] cnt_limit_i = '0;
  logic        trig_o;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  evt_sequencer u0 (
    .clk_i, .rst_ni, .hit_i, .clr_i, .seq_mode_i,
    .first_stage_i, .cnt_mode_i, .cnt_limit_i, .trig_o
  );

  task automatic chk(input logic got, input logic exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: trig_o=%0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  // one cycle of stimulus; exp is trig_o right after the sampling edge
  task automatic cyc(input logic [3:0] h, input logic c, input logic exp, input string req);
    hit_i = h;
    clr_i = c;
    @(posedge clk_i);
    #1;
    chk(trig_o, exp, req);
    hit_i = '0;
    clr_i = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int prog;
    int p [4];
    logic e;
    repeat (3) @(posedge clk_i);
    #1;
    chk(trig_o, 1'b0, "R1");
    rst_ni = 1'b1;
    cyc(4'h0, 1'b0, 1'b0, "R1");

    // R2 R3: ordered mode, every start stage, every hit order
    seq_mode_i = 1'b1;
    for (int f = 0; f < 4; f++) begin
      first_stage_i = 2'(f);
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
          for (int c = 0; c < 4; c++)
            for (int d = 0; d < 4; d++) begin
              if (a == b || a == c || a == d || b == c || b == d || c == d) continue;
              p[0] = a; p[1] = b; p[2] = c; p[3] = d;
              prog = f;
              for (int i = 0; i < 4; i++) begin
                e = 1'b0;
                if (p[i] == prog) begin
                  prog++;
                  if (prog == 4) begin e = 1'b1; prog = f; end
                end
                cyc(4'(1 << p[i]), 1'b0, e, (f == 0) ? "R2" : "R3");
              end
              cyc(4'h0, 1'b1, 1'b0, "R4");
            end
    end

    // R2: same-cycle hits do not chain
    first_stage_i = 2'd0;
    cyc(4'hF, 1'b0, 1'b0, "R2");
    cyc(4'hE, 1'b0, 1'b0, "R2");
    cyc(4'hC, 1'b0, 1'b0, "R2");
    cyc(4'h8, 1'b0, 1'b1, "R2");

    // R4: clear mid-chain, clear beats final hit
    cyc(4'h1, 1'b0, 1'b0, "R4");
    cyc(4'h2, 1'b0, 1'b0, "R4");
    cyc(4'h4, 1'b0, 1'b0, "R4");
    cyc(4'h0, 1'b1, 1'b0, "R4");
    cyc(4'h8, 1'b0, 1'b0, "R4");
    cyc(4'h1, 1'b0, 1'b0, "R4");
    cyc(4'h2, 1'b0, 1'b0, "R4");
    cyc(4'h4, 1'b0, 1'b0, "R4");
    cyc(4'h8, 1'b1, 1'b0, "R4");
    cyc(4'h8, 1'b0, 1'b0, "R4");

    // R6: single pulse and re-arm
    cyc(4'h1, 1'b0, 1'b0, "R6");
    cyc(4'h2, 1'b0, 1'b0, "R6");
    cyc(4'h4, 1'b0, 1'b0, "R6");
    cyc(4'h8, 1'b0, 1'b1, "R6");
    cyc(4'h0, 1'b0, 1'b0, "R6");
    cyc(4'h8, 1'b0, 1'b0, "R6");
    cyc(4'h0, 1'b1, 1'b0, "R6");

    // R5: unordered mode
    seq_mode_i = 1'b0;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++) begin
            if (a == b || a == c || a == d || b == c || b == d || c == d) continue;
            cyc(4'(1 << a), 1'b0, 1'b0, "R5");
            cyc(4'(1 << b), 1'b0, 1'b0, "R5");
            cyc(4'(1 << c), 1'b0, 1'b0, "R5");
            cyc(4'(1 << d), 1'b0, 1'b1, "R5");
          end
    cyc(4'h3, 1'b0, 1'b0, "R5");
    cyc(4'hC, 1'b0, 1'b1, "R5");
    cyc(4'hF, 1'b0, 1'b1, "R5");
    cyc(4'h7, 1'b0, 1'b0, "R5");
    cyc(4'h0, 1'b1, 1'b0, "R4");
    cyc(4'h8, 1'b0, 1'b0, "R4");

    // R7: match mode, single stage
    seq_mode_i = 1'b1;
    first_stage_i = 2'd3;
    cnt_mode_i = 2'd1;
    cnt_limit_i = 32'd3;
    for (int i = 1; i <= 6; i++) cyc(4'h8, 1'b0, (i % 3) == 0, "R7");
    cnt_limit_i = 32'd0;
    for (int i = 0; i < 3; i++) cyc(4'h8, 1'b0, 1'b1, "R7");
    cnt_limit_i = 32'd1;
    for (int i = 0; i < 3; i++) cyc(4'h8, 1'b0, 1'b1, "R7");

    // R9: reserved code acts as off
    cnt_mode_i = 2'd3;
    cnt_limit_i = 32'd4;
    cyc(4'h8, 1'b0, 1'b1, "R9");
    cyc(4'h0, 1'b0, 1'b0, "R9");

    // R8: delay mode
    cnt_mode_i = 2'd2;
    cnt_limit_i = 32'd0;
    cyc(4'h8, 1'b0, 1'b1, "R8");
    cyc(4'h0, 1'b0, 1'b0, "R8");
    cnt_limit_i = 32'd1;
    cyc(4'h8, 1'b0, 1'b0, "R8");
    cyc(4'h0, 1'b0, 1'b1, "R8");
    cyc(4'h0, 1'b0, 1'b0, "R8");
    cnt_limit_i = 32'd5;
    cyc(4'h8, 1'b0, 1'b0, "R8");
    cyc(4'h8, 1'b0, 1'b0, "R8");
    for (int i = 0; i < 3; i++) cyc(4'h0, 1'b0, 1'b0, "R8");
    cyc(4'h0, 1'b0, 1'b1, "R8");
    for (int i = 0; i < 6; i++) cyc(4'h0, 1'b0, 1'b0, "R8");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule